// File: doc/BRIEF.md
# Three-Step Look-Ahead First-Order Recursive Filter

This block is a first-order recursive filter with a single pole. It takes one signed sample per clock and returns one filtered sample per clock. The plain recursion multiplies the last output by the pole and adds the new input. That needs a full multiply-add inside one cycle, which caps the clock. This block unrolls the recursion three steps, so each output depends on the output three samples back and not the last one. The feedback loop then holds three registers, and the multiply, the add and the clamp each get a cycle of their own. Two inputs that a cancelling pole pair adds to the response come from a separate non-recursive section, outside the loop.

The pole is loaded through a strobe. Its square and cube are derived and held in registers. Loading also clears the filter history, so each coefficient starts from rest. The coefficient must not change while samples stream.

Top module: `lah_iir1`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, `out_data` is 0, and the pole is 0, so the block passes samples through unchanged until a coefficient is loaded.
- R2: A sample taken with `in_valid` high at rising edge k produces its result on `out_data`, with `out_valid` high, from just after edge k+3 until edge k+4. `out_valid` is low for every other cycle.
- R3: Samples and outputs are two's-complement DATA_W-bit integers, and the pole `a` is a signed COEF_W-bit fraction with FRAC = COEF_W−1 fraction bits. The output is y(n) = clamp(floor((u(n)·2^FRAC + a·u(n−1) + a2·u(n−2) + a3·y(n−3)) / 2^FRAC)), where the history before the first sample is zero.
- R4: a2 = clamp_c(floor(a·a / 2^FRAC)) and a3 = clamp_c(floor(a2·a / 2^FRAC)), where clamp_c limits a value to the signed COEF_W-bit range. So a2 is never negative, and |a3| never exceeds a2.
- R5: A cycle with `in_valid` low enters the history as a zero sample, whatever the value on `in_data`.
- R6: A high `coef_load` at an edge stores `coef_in` as the pole and clears all history. It also drops any sample offered on that same edge. Right after that edge, `out_valid` and `out_data` are 0. Samples may follow from the second edge after the load onward.
- R7: Each output is clamped to the signed DATA_W-bit range, and the clamped value is the one fed back into the recursion.
- R8: For a positive pole that is an exact power of two (for example 0.5 or 0.25) and a power-of-two impulse, the output equals the plain recursion y(n) = floor(a·y(n−1)/2^FRAC) + u(n).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| coef_load | input | 1 | Load strobe for the pole coefficient, which also clears the history |
| coef_in | input | COEF_W | Signed pole coefficient with FRAC fraction bits |
| in_valid | input | 1 | Sample strobe; when low, the sample counts as zero |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | High on cycles that carry the result of a valid sample |
| out_data | output | DATA_W | Signed filtered sample, clamped |

## Verification
The bench builds the filter with 8-bit samples and an 8-bit coefficient (7 fraction bits). At that size, every one of the 256 pole values can be loaded in turn and run against a random stream with gaps. This covers both signs, the −1 pole whose square has to clamp, and poles near ±1 whose outputs clamp. With 7 fraction bits, power-of-two poles give results exact enough to compare impulse responses with the plain recursion. Short streams of full-scale constants drive the output clamp from both sides.

// File: rtl/lah_pkg.sv
// Package: constants shared by the look-ahead filter modules.
// Assumes: the look-ahead depth is fixed at three steps for this block.
package lah_pkg;
    // Number of loop registers created by the look-ahead rewrite.
    localparam int unsigned LAH_DEPTH = 3;

    // Accumulator width that holds four full-scale product terms.
    function automatic int unsigned lah_acc_width(input int unsigned dw, input int unsigned cw);
        return dw + cw + 2;
    endfunction
endpackage

// File: rtl/lah_coef_gen.sv
// Module: derives and holds the pole coefficient and its square and cube.
// Assumes: after a load, the square is valid one edge later and the cube two
// edges later. Samples arrive no sooner than the second edge after the load.
module lah_coef_gen #(
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic signed [COEF_W-1:0] coef_in,
    output logic signed [COEF_W-1:0] a1,
    output logic signed [COEF_W-1:0] a2,
    output logic signed [COEF_W-1:0] a3
);
    localparam int FRAC = COEF_W - 1;
    localparam int PW   = 2 * COEF_W;
    localparam logic signed [PW-1:0] C_HI = PW'((64'sd1 <<< (COEF_W - 1)) - 64'sd1);
    localparam logic signed [PW-1:0] C_LO = PW'(-(64'sd1 <<< (COEF_W - 1)));

    logic signed [PW-1:0]     sq_full, cb_full, sq_sh, cb_sh;
    logic signed [COEF_W-1:0] sq_sat, cb_sat;

    // Form the scaled products and clamp them to the coefficient range.
    always_comb begin
        sq_full = a1 * a1;
        cb_full = a2 * a1;
        sq_sh   = sq_full >>> FRAC;
        cb_sh   = cb_full >>> FRAC;
        if (sq_sh > C_HI)      sq_sat = C_HI[COEF_W-1:0];
        else if (sq_sh < C_LO) sq_sat = C_LO[COEF_W-1:0];
        else                   sq_sat = sq_sh[COEF_W-1:0];
        if (cb_sh > C_HI)      cb_sat = C_HI[COEF_W-1:0];
        else if (cb_sh < C_LO) cb_sat = C_LO[COEF_W-1:0];
        else                   cb_sat = cb_sh[COEF_W-1:0];
    end

    // Capture the pole on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    a1 <= '0;
        else if (load) a1 <= coef_in;
    end

    // Refresh the square and cube registers every cycle from the held pole.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a2 <= '0;
            a3 <= '0;
        end else begin
            a2 <= sq_sat;
            a3 <= cb_sat;
        end
    end

    assert_square_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        a2 >= 0);

    assert_cube_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (a3 <= $past(a2)) && (a3 >= -$past(a2)));
endmodule

// File: rtl/lah_feedfwd.sv
// Module: non-recursive section that forms u(n)*2^FRAC + a*u(n-1) + a2*u(n-2).
// Assumes: it advances every clock, an invalid cycle counts as a zero sample,
// and a clear empties the whole delay line. Two register stages.
module lah_feedfwd #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 34
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     u_valid,
    input  logic signed [DATA_W-1:0] u_data,
    input  logic signed [COEF_W-1:0] a1,
    input  logic signed [COEF_W-1:0] a2,
    output logic signed [ACC_W-1:0]  f_out
);
    localparam int FRAC = COEF_W - 1;
    localparam int MW   = DATA_W + COEF_W;

    logic signed [DATA_W-1:0] u_cur, u_d1, u_d2, lead;
    logic signed [MW-1:0]     m1, m2;

    // Replace an idle sample with zero.
    always_comb u_cur = u_valid ? u_data : '0;

    // Stage 1: delay line and tap products.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            u_d1 <= '0;
            u_d2 <= '0;
            lead <= '0;
            m1   <= '0;
            m2   <= '0;
        end else begin
            u_d1 <= u_cur;
            u_d2 <= u_d1;
            lead <= u_cur;
            m1   <= a1 * u_d1;
            m2   <= a2 * u_d2;
        end
    end

    // Stage 2: full-precision sum of the current sample and both taps.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) f_out <= '0;
        else f_out <= (ACC_W'(lead) <<< FRAC) + ACC_W'(m1) + ACC_W'(m2);
    end
endmodule

// File: rtl/lah_loop.sv
// Module: recursive core y(n) = clamp((f(n) + a3*y(n-3)) >> FRAC).
// Assumes: f_in carries f(n) for the sample whose y(n-3) product is ready.
// The loop holds three registers: the product, the sum and the clamped output.
module lah_loop #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 34
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic signed [ACC_W-1:0]  f_in,
    input  logic signed [COEF_W-1:0] a3,
    output logic signed [DATA_W-1:0] y_out
);
    localparam int FRAC = COEF_W - 1;
    localparam int MW   = DATA_W + COEF_W;
    localparam logic signed [ACC_W-1:0] Y_HI = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] Y_LO = ACC_W'(-(64'sd1 <<< (DATA_W - 1)));

    logic signed [MW-1:0]     prod;
    logic signed [ACC_W-1:0]  sum, scaled;
    logic signed [DATA_W-1:0] y_next;

    // Scale the sum and clamp it to the sample range.
    always_comb begin
        scaled = sum >>> FRAC;
        if (scaled > Y_HI)      y_next = Y_HI[DATA_W-1:0];
        else if (scaled < Y_LO) y_next = Y_LO[DATA_W-1:0];
        else                    y_next = scaled[DATA_W-1:0];
    end

    // Three loop stages: multiply, add, then clamp.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            prod  <= '0;
            sum   <= '0;
            y_out <= '0;
        end else begin
            prod  <= a3 * y_out;
            sum   <= f_in + ACC_W'(prod);
            y_out <= y_next;
        end
    end

    assert_out_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && ((sum >>> FRAC) > Y_HI)) |=> (y_out == Y_HI[DATA_W-1:0]));

    assert_zero_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && sum == '0) |=> (y_out == '0));
endmodule

// File: rtl/lah_iir1.sv
// Module: top level of the three-step look-ahead first-order recursive filter.
// Assumes: one sample slot per clock and a coefficient held steady while
// streaming. Latency is four registers from the sampling edge to the output.
module lah_iir1 #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     coef_load,
    input  logic signed [COEF_W-1:0] coef_in,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);
    import lah_pkg::*;

    localparam int ACC_W   = int'(lah_acc_width(DATA_W, COEF_W));
    localparam int LATENCY = int'(LAH_DEPTH) + 1;

    logic signed [COEF_W-1:0] a1, a2, a3;
    logic signed [ACC_W-1:0]  f_sum;
    logic [LATENCY-1:0]       vld;
    logic [2:0]               age;

    lah_coef_gen #(.COEF_W(COEF_W)) u_coef (
        .clk(clk), .rst_n(rst_n), .load(coef_load), .coef_in(coef_in),
        .a1(a1), .a2(a2), .a3(a3)
    );

    lah_feedfwd #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_ffwd (
        .clk(clk), .rst_n(rst_n), .clear(coef_load), .u_valid(in_valid),
        .u_data(in_data), .a1(a1), .a2(a2), .f_out(f_sum)
    );

    lah_loop #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_loop (
        .clk(clk), .rst_n(rst_n), .clear(coef_load), .f_in(f_sum),
        .a3(a3), .y_out(out_data)
    );

    // Carry each sample's valid flag alongside the datapath.
    always_ff @(posedge clk) begin
        if (!rst_n || coef_load) vld <= '0;
        else                     vld <= {vld[LATENCY-2:0], in_valid};
    end

    assign out_valid = vld[LATENCY-1];

    // Count edges since reset so the latency check looks back only over valid history.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd5 && !$past(coef_load, 1) && !$past(coef_load, 2) &&
         !$past(coef_load, 3) && !$past(coef_load, 4))
        |-> (out_valid == $past(in_valid, 4)));

    assert_flush_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(coef_load) |-> (!out_valid && out_data == '0));
endmodule

// File: tb/tb_lah_iir1.sv
// Bench: sweeps all poles of an 8-bit build against an arithmetic model.
module tb_lah_iir1;
    localparam int DW = 8;
    localparam int CW = 8;
    localparam int FR = CW - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic coef_load = 1'b0;
    logic signed [CW-1:0] coef_in = '0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic out_valid;
    logic signed [DW-1:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    longint us [0:63];
    longint ys [0:63];
    bit     vs [0:63];

    lah_iir1 #(.DATA_W(DW), .COEF_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .coef_load(coef_load), .coef_in(coef_in),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #10 clk = ~clk;

    function automatic longint clampw(input longint v, input int w);
        longint hi = (64'sd1 <<< (w - 1)) - 1;
        longint lo = -(64'sd1 <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic longint hist(input int n, input bit of_y);
        if (n < 0) return 0;
        return of_y ? ys[n] : us[n];
    endfunction

    task automatic check(input string tag, input longint act, input longint exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Load a pole (offering a sample on the same edge, which must be dropped), then check the flush.
    task automatic load_coef(input int c);
        @(negedge clk);
        coef_load = 1'b1;
        coef_in   = CW'(c);
        in_valid  = 1'b1;
        in_data   = DW'(77);
        @(negedge clk);
        coef_load = 1'b0;
        in_valid  = 1'b0;
        check("R6", longint'(out_valid), 0, "valid after load");
        check("R6", longint'(out_data), 0, "data after load");
    endtask

    // mode 0: random with gaps, 1: impulse of amp, 2: constant amp.
    // direct=1 selects the plain recursion as the model.
    task automatic run(input string tag, input int c, input bit do_load, input int k,
                       input int mode, input int amp, input int gap_pct, input bit direct);
        longint a1, a2, a3, acc;
        a1 = longint'(c);
        a2 = clampw((a1 * a1) >>> FR, CW);
        a3 = clampw((a2 * a1) >>> FR, CW);
        for (int n = 0; n < k; n++) begin
            vs[n] = (mode != 0) || (($urandom % 100) >= gap_pct);
            case (mode)
                0:       us[n] = vs[n] ? longint'($signed(DW'($urandom))) : 0;
                1:       us[n] = (n == 0) ? longint'(amp) : 0;
                default: us[n] = longint'(amp);
            endcase
            if (direct)
                ys[n] = clampw(((a1 * hist(n - 1, 1'b1)) >>> FR) + us[n], DW);
            else begin
                acc = (us[n] <<< FR) + a1 * hist(n - 1, 1'b0) + a2 * hist(n - 2, 1'b0)
                      + a3 * hist(n - 3, 1'b1);
                ys[n] = clampw(acc >>> FR, DW);
            end
        end
        if (do_load) load_coef(c);
        for (int t = 0; t < k + 4; t++) begin
            @(negedge clk);
            if (t >= 1) begin
                int n = t - 4;
                check("R2", longint'(out_valid), (n >= 0) ? longint'(vs[n]) : 0, "out_valid");
                check(tag, longint'(out_data), (n >= 0) ? ys[n] : 0, "out_data");
            end
            if (t < k) begin
                in_valid = vs[t];
                in_data  = vs[t] ? DW'(us[t]) : DW'($urandom);
            end else begin
                in_valid = 1'b0;
                in_data  = DW'($urandom);
            end
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the outputs
        check("R1", longint'(out_valid), 0, "reset out_valid");
        check("R1", longint'(out_data), 0, "reset out_data");
        // R1: zero pole after reset passes samples through
        run("R1", 0, 1'b0, 16, 0, 0, 0, 1'b0);
        // R8: power-of-two poles match the plain recursion
        run("R8", 64, 1'b1, 14, 1, 64, 0, 1'b1);
        run("R8", 32, 1'b1, 12, 1, 64, 0, 1'b1);
        // R5: idle cycles with garbage data count as zero samples
        run("R5", 100, 1'b1, 40, 0, 0, 40, 1'b0);
        run("R5", -90, 1'b1, 40, 0, 0, 60, 1'b0);
        // R7: clamp at both ends of the sample range
        run("R7", 127, 1'b1, 30, 2, 127, 0, 1'b0);
        run("R7", 127, 1'b1, 30, 2, -128, 0, 1'b0);
        run("R7", -128, 1'b1, 30, 2, 127, 0, 1'b0);
        // R4: pole of -1 needs a clamped square
        run("R4", -128, 1'b1, 24, 1, -100, 0, 1'b0);
        // R3: every pole value against a random stream
        for (int c = -128; c < 128; c++) run("R3", c, 1'b1, 20, 0, 0, 15, 1'b0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule